// File: doc/BRIEF.md
# UART Interrupt Priority Resolver

This block gathers the pending interrupt sources of one serial channel and reports the most urgent one as a 6-bit identification code. It also drives a single interrupt request line. Three sources are latched inside the block: a modem-status change, a detected receive character of special meaning (flow-control or match character), and a rising edge on the CTS or RTS pin. Three higher-priority sources (line status, receive data, transmit empty) arrive as plain level inputs that are already resolved elsewhere. They take part in the priority order only.

Each internal source is a two-state machine. `SRC_IDLE` moves to `SRC_PEND` on its set event. `SRC_PEND` returns to `SRC_IDLE` on its clear event when no set event arrives in the same cycle, and otherwise stays in `SRC_PEND`. The modem-change latch is cleared by a modem-status register read strobe. The character and pin-edge latches are cleared by an identification register read strobe, but only when the code shown during that read is their own. The resolved level is one of `LVL_NONE`, `LVL_LSTAT`, `LVL_RXD`, `LVL_TXE`, `LVL_MODEM`, `LVL_CHAR` or `LVL_FLOW`. The code output is a combinational function of the latched state.

Top module: `uart_irq_resolver`

## Requirements
- R1: After reset, and whenever nothing is pending, `isr_code` is 6'b000001 and `irq` is 0.
- R2: `hi_pend[2]`, `hi_pend[1]` and `hi_pend[0]` report codes 6'b000110, 6'b000100 and 6'b000010. They rank in that order and all rank above the three latched sources.
- R3: A pulse on any bit of `msr_delta` latches the modem level, which reports 6'b000000. Only a `msr_rd` strobe clears it, and the cleared state shows on the cycle after the strobe.
- R4: An `isr_rd` strobe never clears the modem level.
- R5: The character level is set only while `enh_mode` is 1, by `ev_xoff` with `inband_fc_en`, by `ev_xoff2` with `spec_det_en`, or by `ev_spec` with `nine_bit_en`. Any other combination leaves it clear.
- R6: The character level reports 6'b010000. An `isr_rd` strobe clears it while that code is shown.
- R7: A low-to-high change on `cts_n_pin` or `rts_n_pin` sets the pin-edge level, which reports 6'b100000 after the third rising clock edge following the change. A high-to-low change sets nothing.
- R8: An `isr_rd` strobe clears the pin-edge level while 6'b100000 is shown.
- R9: Priority is modem, then character, then pin edge. An `isr_rd` strobe clears only the level shown during it, and a lower pending level stays latched.
- R10: A set event in the same cycle as a clear strobe of the same level leaves that level pending.
- R11: `irq` is 1 exactly when `isr_code` differs from 6'b000001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hi_pend | input | 3 | Higher-priority pending levels: [2] line status, [1] receive data, [0] transmit empty |
| msr_delta | input | 4 | Modem-status change flag pulses |
| msr_rd | input | 1 | Modem-status register read strobe |
| isr_rd | input | 1 | Identification register read strobe |
| enh_mode | input | 1 | Enhanced mode enable |
| inband_fc_en | input | 1 | In-band flow control enable |
| spec_det_en | input | 1 | Special-character detection enable |
| nine_bit_en | input | 1 | 9-bit mode enable |
| ev_xoff | input | 1 | Valid XOFF received pulse |
| ev_xoff2 | input | 1 | Second XOFF character match pulse |
| ev_spec | input | 1 | Special character 1 to 4 match pulse |
| cts_n_pin | input | 1 | Asynchronous CTS pin, active low |
| rts_n_pin | input | 1 | RTS pin level, active low |
| isr_code | output | 6 | Highest-priority pending code |
| irq | output | 1 | Interrupt request |

## Verification
Each latch's state shows at the code output in the cycle after the set or clear strobe. A latch stuck in the wrong state therefore appears as a wrong code within one cycle, as long as no higher level hides it. Because of this, the bench clears the higher levels one at a time and checks each lower level as it is uncovered. The pin path has three register stages, so a synchronizer with a missing or extra stage shows up as the pin-edge code arriving one edge early or late. A clear routed to the wrong latch shows as a code that survives its own read, or as a lower level that disappears.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic {
        SRC_IDLE,
        SRC_PEND
    } src_state_e;

    typedef enum logic [2:0] {
        LVL_NONE,
        LVL_LSTAT,
        LVL_RXD,
        LVL_TXE,
        LVL_MODEM,
        LVL_CHAR,
        LVL_FLOW
    } irq_level_e;

    localparam int CODE_W = 6;

    function automatic logic [CODE_W-1:0] level_code(input irq_level_e lvl);
        logic [CODE_W-1:0] c;
        unique case (lvl)
            LVL_LSTAT: c = 6'b000110;
            LVL_RXD:   c = 6'b000100;
            LVL_TXE:   c = 6'b000010;
            LVL_MODEM: c = 6'b000000;
            LVL_CHAR:  c = 6'b010000;
            LVL_FLOW:  c = 6'b100000;
            default:   c = 6'b000001;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic pend
);

    src_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: if (set_evt)             state_d = SRC_PEND;
            SRC_PEND: if (clr_evt && !set_evt) state_d = SRC_IDLE;
            default:                           state_d = SRC_IDLE;
        endcase
    end

    always_comb pend = (state_q == SRC_PEND);

    // A set event in the same cycle as a clear keeps the level pending.
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> pend);

    // A clear with no set event empties the latch (used by R3, R6 and R8).
    assert_clear_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !pend);

endmodule

// File: rtl/flow_edge_detect.sv
module flow_edge_detect #(
    parameter int PINS   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pins,
    output logic            rise
);

    localparam int LAST = STAGES - 1;

    logic [PINS-1:0] sync_q [STAGES];
    logic [PINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= '1;
        else        sync_q[0] <= pins;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= '1;
            else        sync_q[s] <= sync_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= sync_q[LAST];
    end

    always_comb rise = |(sync_q[LAST] & ~prev_q);

    // The compare register catches up, so a reported edge has a high pin after it.
    assert_edge_settles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (prev_q != '0));

endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder
    import uart_irq_pkg::*;
(
    input  logic [2:0]  hi_pend,
    input  logic        mdm_pend,
    input  logic        chr_pend,
    input  logic        flow_pend,
    output irq_level_e  level
);

    always_comb begin
        if      (hi_pend[2]) level = LVL_LSTAT;
        else if (hi_pend[1]) level = LVL_RXD;
        else if (hi_pend[0]) level = LVL_TXE;
        else if (mdm_pend)   level = LVL_MODEM;
        else if (chr_pend)   level = LVL_CHAR;
        else if (flow_pend)  level = LVL_FLOW;
        else                 level = LVL_NONE;
    end

endmodule

// File: rtl/uart_irq_resolver.sv
module uart_irq_resolver
    import uart_irq_pkg::*;
#(
    parameter int MSR_FLAGS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           hi_pend,
    input  logic [MSR_FLAGS-1:0] msr_delta,
    input  logic                 msr_rd,
    input  logic                 isr_rd,
    input  logic                 enh_mode,
    input  logic                 inband_fc_en,
    input  logic                 spec_det_en,
    input  logic                 nine_bit_en,
    input  logic                 ev_xoff,
    input  logic                 ev_xoff2,
    input  logic                 ev_spec,
    input  logic                 cts_n_pin,
    input  logic                 rts_n_pin,
    output logic [CODE_W-1:0]    isr_code,
    output logic                 irq
);

    localparam logic [CODE_W-1:0] IDLE_CODE = 6'b000001;

    logic       mdm_pend, chr_pend, flow_pend;
    logic       mdm_set, chr_set, flow_set;
    logic       chr_clr, flow_clr;
    irq_level_e level;

    always_comb begin
        mdm_set  = |msr_delta;
        chr_set  = enh_mode && ((ev_xoff  && inband_fc_en) ||
                                (ev_xoff2 && spec_det_en)  ||
                                (ev_spec  && nine_bit_en));
        chr_clr  = isr_rd && (level == LVL_CHAR);
        flow_clr = isr_rd && (level == LVL_FLOW);
    end

    irq_src_latch u_mdm (
        .clk(clk), .rst_n(rst_n), .set_evt(mdm_set), .clr_evt(msr_rd), .pend(mdm_pend)
    );

    irq_src_latch u_chr (
        .clk(clk), .rst_n(rst_n), .set_evt(chr_set), .clr_evt(chr_clr), .pend(chr_pend)
    );

    flow_edge_detect #(.PINS(2), .STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pins({rts_n_pin, cts_n_pin}), .rise(flow_set)
    );

    irq_src_latch u_flow (
        .clk(clk), .rst_n(rst_n), .set_evt(flow_set), .clr_evt(flow_clr), .pend(flow_pend)
    );

    irq_prio_encoder u_prio (
        .hi_pend(hi_pend), .mdm_pend(mdm_pend), .chr_pend(chr_pend),
        .flow_pend(flow_pend), .level(level)
    );

    always_comb begin
        isr_code = level_code(level);
        irq      = (level != LVL_NONE);
    end

    assert_idle_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_pend == 3'b000 && !mdm_pend && !chr_pend && !flow_pend)
            |-> (isr_code == IDLE_CODE && !irq));

    assert_msr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && msr_delta == '0) |=> !mdm_pend);

    assert_isr_keeps_modem_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && mdm_pend && !msr_rd) |=> mdm_pend);

    assert_char_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh_mode && !chr_pend) |=> !chr_pend);

    assert_lower_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && isr_code == 6'b010000 && flow_pend) |=> flow_pend);

endmodule

// File: tb/uart_irq_resolver_test.sv
module uart_irq_resolver_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hi_pend = '0;
    logic [3:0] msr_delta = '0;
    logic       msr_rd = 0, isr_rd = 0;
    logic       enh_mode = 0, inband_fc_en = 0, spec_det_en = 0, nine_bit_en = 0;
    logic       ev_xoff = 0, ev_xoff2 = 0, ev_spec = 0;
    logic       cts_n_pin = 1, rts_n_pin = 1;
    logic [5:0] isr_code;
    logic       irq;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    uart_irq_resolver uut (
        .clk(clk), .rst_n(rst_n), .hi_pend(hi_pend), .msr_delta(msr_delta),
        .msr_rd(msr_rd), .isr_rd(isr_rd), .enh_mode(enh_mode),
        .inband_fc_en(inband_fc_en), .spec_det_en(spec_det_en),
        .nine_bit_en(nine_bit_en), .ev_xoff(ev_xoff), .ev_xoff2(ev_xoff2),
        .ev_spec(ev_spec), .cts_n_pin(cts_n_pin), .rts_n_pin(rts_n_pin),
        .isr_code(isr_code), .irq(irq)
    );

    // {hi_pend[2:0], modem, char, pin edge, expected code}
    localparam logic [11:0] VECS [10] = '{
        {3'b000, 3'b000, 6'b000001},
        {3'b000, 3'b100, 6'b000000},
        {3'b000, 3'b010, 6'b010000},
        {3'b000, 3'b001, 6'b100000},
        {3'b000, 3'b111, 6'b000000},
        {3'b000, 3'b011, 6'b010000},
        {3'b001, 3'b111, 6'b000010},
        {3'b010, 3'b111, 6'b000100},
        {3'b100, 3'b111, 6'b000110},
        {3'b011, 3'b000, 6'b000100}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [5:0] exp);
        logic exp_irq;
        #1;
        exp_irq = (exp != 6'b000001);
        total++;
        if (isr_code !== exp || irq !== exp_irq) begin
            fails++;
            $display("FAIL %s (R11 irq): code=%b irq=%b expected code=%b irq=%b",
                     req, isr_code, irq, exp, exp_irq);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        hi_pend = '0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic pulse_msr(input logic [3:0] bits);
        msr_delta = bits; tick(); msr_delta = '0;
    endtask

    task automatic pulse_char(input logic x, input logic x2, input logic s);
        ev_xoff = x; ev_xoff2 = x2; ev_spec = s;
        tick();
        ev_xoff = 0; ev_xoff2 = 0; ev_spec = 0;
    endtask

    task automatic read_isr();
        isr_rd = 1; tick(); isr_rd = 0;
    endtask

    task automatic read_msr();
        msr_rd = 1; tick(); msr_rd = 0;
    endtask

    task automatic rts_rise();
        rts_n_pin = 0; repeat (4) tick();
        rts_n_pin = 1; repeat (3) tick();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R1 reset", 6'b000001);

        // Vector table: priority across all six levels (R2, R9).
        enh_mode = 1; inband_fc_en = 1; spec_det_en = 1; nine_bit_en = 1;
        for (int i = 0; i < 10; i++) begin
            do_reset();
            hi_pend = VECS[i][11:9];
            if (VECS[i][8]) pulse_msr(4'b0001);
            if (VECS[i][7]) pulse_char(1, 0, 0);
            if (VECS[i][6]) rts_rise();
            tick();
            check("R2/R9 vector", VECS[i][5:0]);
        end

        // R3, R4: modem level set and clear rules
        do_reset();
        pulse_msr(4'b1000);
        check("R3 modem set", 6'b000000);
        read_isr();
        check("R4 isr read keeps modem", 6'b000000);
        read_msr();
        check("R3 msr read clears", 6'b000001);

        // R5: gating of character events
        do_reset();
        enh_mode = 0; inband_fc_en = 1; spec_det_en = 1; nine_bit_en = 1;
        pulse_char(1, 1, 1);
        check("R5 not enhanced", 6'b000001);
        enh_mode = 1; inband_fc_en = 0; spec_det_en = 0; nine_bit_en = 0;
        pulse_char(1, 0, 0);
        check("R5 xoff without flow control", 6'b000001);
        pulse_char(0, 1, 0);
        check("R5 xoff2 without detection", 6'b000001);
        pulse_char(0, 0, 1);
        check("R5 spec without 9-bit", 6'b000001);
        spec_det_en = 1;
        pulse_char(0, 1, 0);
        check("R5 xoff2 sets", 6'b010000);
        read_isr();
        check("R6 isr read clears char", 6'b000001);
        nine_bit_en = 1;
        pulse_char(0, 0, 1);
        check("R5 spec sets", 6'b010000);
        read_isr();
        check("R6 clear again", 6'b000001);
        inband_fc_en = 1;
        pulse_char(1, 0, 0);
        check("R6 xoff code", 6'b010000);
        read_isr();

        // R7: pin edge timing and direction
        do_reset();
        cts_n_pin = 0; repeat (4) tick();
        check("R7 falling edge ignored", 6'b000001);
        cts_n_pin = 1;
        tick(); tick();
        check("R7 not yet after two edges", 6'b000001);
        tick();
        check("R7 set on third edge", 6'b100000);
        read_isr();
        check("R8 isr read clears pin edge", 6'b000001);

        // R9: selective clear with all three pending
        do_reset();
        pulse_msr(4'b0010);
        pulse_char(1, 0, 0);
        rts_rise();
        check("R9 modem on top", 6'b000000);
        read_isr();
        check("R9 isr read keeps modem", 6'b000000);
        read_msr();
        check("R9 char uncovered", 6'b010000);
        read_isr();
        check("R9 pin edge kept", 6'b100000);
        read_isr();
        check("R8 last level cleared", 6'b000001);

        // R10: set and clear in the same cycle
        do_reset();
        pulse_char(1, 0, 0);
        isr_rd = 1; ev_xoff = 1; tick();
        isr_rd = 0; ev_xoff = 0;
        check("R10 char set wins", 6'b010000);
        read_isr();
        pulse_msr(4'b0100);
        msr_rd = 1; msr_delta = 4'b0001; tick();
        msr_rd = 0; msr_delta = '0;
        check("R10 modem set wins", 6'b000000);
        read_msr();
        check("R10 modem then clears", 6'b000001);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

endmodule